// File: doc/BRIEF.md
# I2C Register Slave with Staged Commit

This block is a serial two-wire bus slave that can both receive and transmit. A bus master reaches an internal file of byte registers through an 8-bit sub-address pointer that steps forward after every data byte, in both directions. Bytes written by the master never reach the working registers directly. They land in a shadow copy and stay there until the master arms a transfer by writing any byte to the reserved sub-address FFh.

Once armed, the transfer does not happen at once. Each register belongs to one of three commit groups, and each group waits for its own timing event before it copies its shadow bytes into the active registers. The events are the rising edge of a main-input vertical sync, the rising edge of a secondary-input vertical sync, and the rising edge of an output-cycle start pulse. Three read-only status bytes at 80h, 81h and 82h show, in bit 0, whether each group still waits for its event. The active registers drive the block's data output and are also what the bus reads back.

SCL and SDA are oversampled in the system clock domain and pass a short glitch filter. SDA is driven open-drain, through an enable that pulls the line low. The design targets a 50 MHz system clock with SCL at 100 kHz or 400 kHz.

Top module: `i2c_staged_regs`

## Requirements
- R1: The slave answers only the address byte BCh (7-bit address 1011110 with write bit 0) and BDh (read bit 1) by pulling SDA low in the acknowledge slot. After any other address byte it does not acknowledge and leaves SDA released until the next START.
- R2: In a write transfer the slave acknowledges the sub-address byte and every data byte. Each data byte goes to the current pointer, and the pointer then steps by one, wrapping from FFh to 00h.
- R3: After a repeated START with BDh, the slave sends bytes MSB first, beginning at the pointer and stepping it after each byte. A master ACK (SDA low) asks for the next byte. A master NACK ends the transfer with SDA released.
- R4: A data write to a mapped register (sub-address below 16) changes only its shadow byte. Its active value, on the output and on bus reads, stays the same until a commit.
- R5: A write of any byte to FFh arms all three groups. Afterwards, sub-addresses 80h, 81h and 82h read 01h until their group commits, and 00h otherwise.
- R6: Registers 0 to 5 commit on a rising edge of the main sync input, registers 6 to 10 on a rising edge of the secondary sync input, and registers 11 to 15 on a rising edge of the output-start input. A commit happens only when the group is armed, touches no other group, and clears that group's status to 00h.
- R7: A sync edge on a group that is not armed leaves its active registers unchanged, even when its shadow bytes differ.
- R8: A second store command while a group is still armed keeps its status at 01h, and the commit then copies the newest shadow values.
- R9: A read of sub-addresses 10h to 7Fh or 83h to FFh returns 00h. Writes to those sub-addresses, and to 80h to 82h, change neither any register nor any status.
- R10: Writes and reads work with SCL at both 100 kHz and 400 kHz on the 50 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| vs_main_i | input | 1 | Main-input vertical sync, asynchronous |
| vs_sec_i | input | 1 | Secondary-input vertical sync, asynchronous |
| out_start_i | input | 1 | Output-cycle start pulse, asynchronous |
| active_regs_o | output | 128 | Active registers, register n in bits 8n+7..8n |

## Verification
The assertions assume that SDA changes only while SCL is low, except at START and STOP. They also assume that every SDA change and every SCL phase lasts longer than the two-stage synchroniser plus the glitch filter, and that sync pulses stay high and low for several system clocks. The bench master changes SDA a quarter bit period after each SCL edge, with a quarter period of at least 14 system clocks, and releases SDA whenever the slave owns the line. It holds each sync pulse for 8 clocks. Random bursts over mapped, unmapped, status and store sub-addresses are compared against a bench-side shadow, active and pending model.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    PS_IDLE,
    PS_ADDR,
    PS_ADDR_ACK,
    PS_SUB,
    PS_SUB_ACK,
    PS_WDATA,
    PS_WDATA_ACK,
    PS_TX,
    PS_TX_ACK
  } proto_state_e;

  localparam int unsigned GRP_COUNT = 3;
  localparam int unsigned GRP_MAIN  = 0;
  localparam int unsigned GRP_SEC   = 1;
  localparam int unsigned GRP_OUT   = 2;
endpackage

// File: rtl/i2cs_sync_edge.sv
module i2cs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
      rise_o <= sync_q[STAGES-1] & ~last_q;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [1:0] raw;
  logic [1:0] filt;
  logic [1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          level_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q  <= 2'b11;
        cnt_q   <= '0;
        level_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw[g]};
        if (sync_q[1] == level_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
          level_q <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign filt[g] = level_q;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 2'b11;
    else     prev_q <= filt;
  end

  assign sda_o      = filt[1];
  assign scl_rise_o = filt[0] & ~prev_q[0];
  assign scl_fall_o = ~filt[0] & prev_q[0];
  assign start_o    = filt[0] & prev_q[0] & prev_q[1] & ~filt[1];
  assign stop_o     = filt[0] & prev_q[0] & ~prev_q[1] & filt[1];
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
  import i2cs_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h5E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_f,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr_o,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  proto_state_e state;
  logic [2:0]   bitcnt;
  logic [7:0]   rx_sh;
  logic [7:0]   tx_sh;
  logic [7:0]   ptr;
  logic         rd_mode;
  logic         rx_full;
  logic         mack;

  assign rd_addr_o = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_IDLE;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      rd_mode   <= 1'b0;
      rx_full   <= 1'b0;
      mack      <= 1'b1;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_ev) begin
        state    <= PS_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_ev) begin
        state    <= PS_ADDR;
        bitcnt   <= '0;
        rx_full  <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          PS_ADDR, PS_SUB, PS_WDATA: begin
            rx_sh   <= {rx_sh[6:0], sda_f};
            bitcnt  <= bitcnt + 1'b1;
            rx_full <= (bitcnt == 3'd7);
          end
          PS_TX_ACK: mack <= sda_f;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          PS_ADDR: begin
            if (rx_full) begin
              rx_full <= 1'b0;
              if (rx_sh[7:1] == SLV_ADDR) begin
                rd_mode  <= rx_sh[0];
                sda_oe_o <= 1'b1;
                state    <= PS_ADDR_ACK;
              end else begin
                state <= PS_IDLE;
              end
            end
          end
          PS_SUB: begin
            if (rx_full) begin
              rx_full  <= 1'b0;
              ptr      <= rx_sh;
              sda_oe_o <= 1'b1;
              state    <= PS_SUB_ACK;
            end
          end
          PS_WDATA: begin
            if (rx_full) begin
              rx_full   <= 1'b0;
              wr_en_o   <= 1'b1;
              wr_addr_o <= ptr;
              wr_data_o <= rx_sh;
              ptr       <= ptr + 1'b1;
              sda_oe_o  <= 1'b1;
              state     <= PS_WDATA_ACK;
            end
          end
          PS_ADDR_ACK: begin
            bitcnt <= '0;
            if (rd_mode) begin
              tx_sh    <= rd_data;
              sda_oe_o <= ~rd_data[7];
              ptr      <= ptr + 1'b1;
              state    <= PS_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= PS_SUB;
            end
          end
          PS_SUB_ACK, PS_WDATA_ACK: begin
            sda_oe_o <= 1'b0;
            bitcnt   <= '0;
            state    <= PS_WDATA;
          end
          PS_TX: begin
            if (bitcnt == 3'd7) begin
              sda_oe_o <= 1'b0;
              state    <= PS_TX_ACK;
            end else begin
              tx_sh    <= {tx_sh[6:0], 1'b0};
              sda_oe_o <= ~tx_sh[6];
              bitcnt   <= bitcnt + 1'b1;
            end
          end
          PS_TX_ACK: begin
            if (!mack) begin
              tx_sh    <= rd_data;
              sda_oe_o <= ~rd_data[7];
              ptr      <= ptr + 1'b1;
              bitcnt   <= '0;
              state    <= PS_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= PS_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == PS_IDLE) |-> !sda_oe_o); // R1
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> sda_oe_o); // R2
  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (ptr == wr_addr_o + 8'd1)); // R2
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
  import i2cs_pkg::*;
#(
  parameter int         NUM_REGS   = 16,
  parameter int         MAIN_REGS  = 6,
  parameter int         SEC_REGS   = 5,
  parameter logic [7:0] STORE_ADDR = 8'hFF,
  parameter logic [7:0] STAT_BASE  = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_addr,
  input  logic [GRP_COUNT-1:0]  commit_ev,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] active_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  function automatic int grp_of(input int idx);
    if (idx < MAIN_REGS)            return GRP_MAIN;
    if (idx < MAIN_REGS + SEC_REGS) return GRP_SEC;
    return GRP_OUT;
  endfunction

  logic [7:0]           shadow_q [NUM_REGS];
  logic [7:0]           active_q [NUM_REGS];
  logic [GRP_COUNT-1:0] pend_q;
  logic [GRP_COUNT-1:0] commit_go;
  logic                 store_hit;
  logic                 map_hit;

  assign store_hit = wr_en && (wr_addr == STORE_ADDR);
  assign map_hit   = wr_en && (int'(wr_addr) < NUM_REGS);
  assign commit_go = pend_q & commit_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) shadow_q[i] <= '0;
    end else if (map_hit) begin
      shadow_q[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  for (genvar g = 0; g < GRP_COUNT; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst)               pend_q[g] <= 1'b0;
      else if (store_hit)    pend_q[g] <= 1'b1;
      else if (commit_ev[g]) pend_q[g] <= 1'b0;
    end

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (commit_ev[g] && !store_hit) |=> !pend_q[g]); // R6
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int GRP = grp_of(i);

    always_ff @(posedge clk) begin
      if (rst)                 active_q[i] <= '0;
      else if (commit_go[GRP]) active_q[i] <= shadow_q[i];
    end

    assign active_o[i*8 +: 8] = active_q[i];

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !commit_go[GRP] |=> $stable(active_q[i])); // R4
    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (rst)
      commit_go[GRP] |=> (active_q[i] == $past(shadow_q[i]))); // R6
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NUM_REGS) begin
      rd_data = active_q[rd_addr[IDX_W-1:0]];
    end else if (rd_addr == STAT_BASE) begin
      rd_data = {7'd0, pend_q[GRP_MAIN]};
    end else if (rd_addr == STAT_BASE + 8'd1) begin
      rd_data = {7'd0, pend_q[GRP_SEC]};
    end else if (rd_addr == STAT_BASE + 8'd2) begin
      rd_data = {7'd0, pend_q[GRP_OUT]};
    end
  end

  AST_STORE_ARMS: assert property (@(posedge clk) disable iff (rst)
    store_hit |=> (pend_q == '1)); // R5
endmodule

// File: rtl/i2c_staged_regs.sv
module i2c_staged_regs
  import i2cs_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h5E,
  parameter int         NUM_REGS    = 16,
  parameter int         MAIN_REGS   = 6,
  parameter int         SEC_REGS    = 5,
  parameter int         FILT_CYCLES = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  vs_main_i,
  input  logic                  vs_sec_i,
  input  logic                  out_start_i,
  output logic [NUM_REGS*8-1:0] active_regs_o
);
  logic                 sda_f, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0]           rd_addr, rd_data, wr_addr, wr_data;
  logic                 wr_en;
  logic [GRP_COUNT-1:0] sync_raw;
  logic [GRP_COUNT-1:0] commit_ev;

  assign sync_raw = {out_start_i, vs_sec_i, vs_main_i};

  i2cs_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_f),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2cs_proto #(.SLV_ADDR(SLV_ADDR)) u_proto (
    .clk(clk), .rst(rst), .sda_f(sda_f), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .rd_addr_o(rd_addr), .sda_oe_o(sda_oe_o),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  for (genvar g = 0; g < GRP_COUNT; g++) begin : g_sync
    i2cs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_i(sync_raw[g]), .rise_o(commit_ev[g])
    );
  end

  i2cs_regbank #(
    .NUM_REGS(NUM_REGS), .MAIN_REGS(MAIN_REGS), .SEC_REGS(SEC_REGS)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .commit_ev(commit_ev),
    .rd_data(rd_data), .active_o(active_regs_o)
  );
endmodule

// File: tb/i2c_staged_regs_tb.sv
`timescale 1ns/1ps
module i2c_staged_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [2:0] syncs = 3'b000;
  logic [127:0] act;
  wire  sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_staged_regs u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .vs_main_i(syncs[0]), .vs_sec_i(syncs[1]), .out_start_i(syncs[2]),
    .active_regs_o(act)
  );

  int checks = 0;
  int errors = 0;
  int q = 14;
  bit done = 1'b0;
  logic [7:0] shadow_m [16];
  logic [7:0] active_m [16];
  bit   [2:0] pend_m;
  logic [7:0] wbuf [4];

  function automatic int grp_of(input int i);
    if (i < 6)  return 0;
    if (i < 11) return 1;
    return 2;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a < 8'd16)  return active_m[a[3:0]];
    if (a == 8'h80) return {7'd0, pend_m[0]};
    if (a == 8'h81) return {7'd0, pend_m[1]};
    if (a == 8'h82) return {7'd0, pend_m[2]};
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(q); scl_m = 1'b1; wq(q); sda_m = 1'b0; wq(q); scl_m = 1'b0; wq(q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(q); scl_m = 1'b1; wq(q); sda_m = 1'b1; wq(q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(q); scl_m = 1'b1; wq(2*q); scl_m = 1'b0; wq(q);
    end
    sda_m = 1'b1; wq(q); scl_m = 1'b1; wq(q);
    ack = !sda_line;
    wq(q); scl_m = 1'b0; wq(q);
  endtask

  task automatic rbyte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(q); scl_m = 1'b1; wq(q); b = {b[6:0], sda_line}; wq(q); scl_m = 1'b0; wq(q);
    end
    sda_m = nack; wq(q); scl_m = 1'b1; wq(2*q); scl_m = 1'b0; wq(q);
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a < 8'd16) shadow_m[a[3:0]] = d;
    else if (a == 8'hFF) pend_m = 3'b111;
  endtask

  task automatic bus_write(input logic [7:0] sub, input int n);
    bit ack;
    logic [7:0] p = sub;
    i2c_start();
    wbyte(8'hBC, ack); chk(ack, "R1 write address ack", ack, 1);
    wbyte(sub, ack);   chk(ack, "R2 sub-address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      wbyte(wbuf[k], ack); chk(ack, "R2 data ack", ack, 1);
      model_write(p, wbuf[k]);
      p = p + 8'd1;
    end
    i2c_stop();
  endtask

  task automatic bus_store();
    wbuf[0] = 8'($urandom);
    bus_write(8'hFF, 1);
  endtask

  task automatic bus_read(input logic [7:0] sub, input int n, input string tag);
    bit ack;
    logic [7:0] p = sub;
    logic [7:0] got;
    i2c_start();
    wbyte(8'hBC, ack); chk(ack, "R1 write address ack", ack, 1);
    wbyte(sub, ack);   chk(ack, "R2 sub-address ack", ack, 1);
    i2c_start();
    wbyte(8'hBD, ack); chk(ack, "R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k == n - 1, got);
      chk(got == model_read(p), tag, got, model_read(p));
      p = p + 8'd1;
    end
    wq(4);
    chk(sda_oe == 1'b0, "R3 released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic pulse(input int g);
    syncs[g] = 1'b1; wq(8); syncs[g] = 1'b0; wq(8);
    if (pend_m[g]) begin
      for (int i = 0; i < 16; i++) if (grp_of(i) == g) active_m[i] = shadow_m[i];
      pend_m[g] = 1'b0;
    end
  endtask

  task automatic check_active(input string tag);
    for (int i = 0; i < 16; i++)
      chk(act[i*8 +: 8] == active_m[i], tag, act[i*8 +: 8], active_m[i]);
  endtask

  initial begin
    bit ack;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin shadow_m[i] = 8'h00; active_m[i] = 8'h00; end
    pend_m = 3'b000;
    wq(5); rst = 1'b0; wq(5);

    check_active("R4 reset value");
    bus_read(8'h80, 3, "R5 status after reset");

    // R1: foreign address is not acknowledged, bus stays released
    i2c_start();
    wbyte(8'hA0, ack); chk(!ack, "R1 foreign address nack", ack, 0);
    wbyte(8'h00, ack); chk(!ack, "R1 no ack after mismatch", ack, 0);
    i2c_stop();
    i2c_start();
    wbyte(8'hBE, ack); chk(!ack, "R1 near-miss address nack", ack, 0);
    i2c_stop();

    // R4: fill shadow, active unchanged
    for (int i = 0; i < 16; i += 4) begin
      for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'h30 + i + k);
      bus_write(8'(i), 4);
    end
    check_active("R4 shadow only");
    bus_read(8'h00, 3, "R4 read returns active");

    bus_store();
    bus_read(8'h80, 3, "R5 status armed");
    check_active("R4 store alone no change");

    pulse(0);
    check_active("R6 main commit");
    bus_read(8'h80, 3, "R6 status after main");
    pulse(1);
    check_active("R6 secondary commit");

    // R7: no store, edge ignored
    wbuf[0] = 8'hA5; bus_write(8'h02, 1);
    pulse(0);
    check_active("R7 unarmed edge");
    chk(act[2*8 +: 8] == 8'h32, "R7 reg2 kept", act[2*8 +: 8], 8'h32);

    // R8: double store, newest value wins
    wbuf[0] = 8'h11; bus_write(8'd11, 1);
    bus_store();
    wbuf[0] = 8'h22; bus_write(8'd11, 1);
    bus_store();
    bus_read(8'h82, 1, "R8 status still armed");
    pulse(2);
    chk(act[11*8 +: 8] == 8'h22, "R8 newest committed", act[11*8 +: 8], 8'h22);
    bus_read(8'h80, 3, "R8 status after output start");
    pulse(1);
    pulse(0);
    check_active("R6 remaining commits");

    // R9: unmapped and status writes ignored
    wbuf[0] = 8'h77; wbuf[1] = 8'h66; bus_write(8'h10, 2);
    wbuf[0] = 8'h01; wbuf[1] = 8'h01; wbuf[2] = 8'h01; bus_write(8'h80, 3);
    bus_read(8'h0F, 4, "R9 unmapped reads zero");
    bus_read(8'h80, 3, "R9 status unaffected");

    // R2: pointer wraps FFh -> 00h, store in passing
    wbuf[0] = 8'h00; wbuf[1] = 8'h9C; bus_write(8'hFF, 2);
    pulse(0);
    check_active("R2 wrap write");

    // R10: 400 kHz and 100 kHz
    q = 31;
    wbuf[0] = 8'h5A; bus_write(8'h07, 1); bus_store(); pulse(1);
    bus_read(8'h07, 1, "R10 400 kHz");
    q = 125;
    wbuf[0] = 8'hC3; bus_write(8'h0C, 1);
    q = 14; bus_store(); pulse(2); q = 125;
    bus_read(8'h0C, 1, "R10 100 kHz");
    q = 14;

    // Random bursts
    for (int it = 0; it < 12; it++) begin
      logic [7:0] s;
      int n;
      case ($urandom % 4)
        0: s = 8'h80;
        1: s = 8'hFE;
        default: s = 8'($urandom % 18);
      endcase
      n = 1 + ($urandom % 3);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      bus_write(s, n);
      if ($urandom % 2) bus_store();
      pulse($urandom % 3);
      if ($urandom % 2) pulse($urandom % 3);
      check_active("R6 random commit");
      s = ($urandom % 4 == 0) ? 8'h80 : 8'($urandom % 18);
      bus_read(s, 1 + ($urandom % 3), "R3 random read");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule